// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical timing strobes for a video raster from a bank of programmable interval registers. A pixel-clock counter walks each line, and a line counter walks each frame. Both counters are one-based. Windowed compares against the register bank produce horizontal blank, horizontal sync, vertical blank and vertical sync. They also produce a cursor window, or a separate horizontal and vertical gate pair, and a vertical interrupt strobe.

Every edge is measured from the start of horizontal blank, which counter value 1 produces. An edge programmed with value n therefore appears on count n+1. Software writes registers through a plain address/data/strobe port. Timing values go into a shadow copy and move to the working copy only at a frame boundary, or at once while the counters are stopped. The control word takes effect immediately. It holds the per-output polarity, the run bit and the gate-mode bit.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, the four polarity-controlled outputs (hblank_o, hsync_o, vblank_o, vsync_o) sit high, which is their inactive level for the reset polarity 0. The cursor, gate and interrupt outputs sit low.
- R2: While running, the pixel counter takes the values 1 up to the line total (address 3) and then returns to 1. Horizontal blank (width at address 2) is active on counts 1 to the width inclusive. Each output shows the decode of the counter state one clock later.
- R3: Bit 0 of a value written to the line total (address 3) is discarded, so the line length is always even. A write of 13 gives a 12-clock line.
- R4: Horizontal sync is active on counts from the front porch (address 0) plus 1 to the sync end (address 1) inclusive.
- R5: The line counter advances by one when a line ends and returns to 1 after the frame total (address 7). Vertical blank is active on lines 1 to the width at address 6. Vertical sync is active on lines from the porch (address 4) plus 1 to the end (address 5).
- R6: Control word bits 0 to 3 set the polarity of hblank_o, hsync_o, vblank_o and vsync_o in that order. A value of 1 makes the output active high and a value of 0 makes it active low. A change applies on the clock after the write.
- R7: While control bit 4 (run) is 0, both counters hold and every output stays constant.
- R8: While running, timing writes to addresses 0 to 13 take effect only on the last clock of a frame. While stopped, they take effect on the next clock.
- R9: With control bit 5 at 0, cursor_o is active when the pixel count lies in (address 8, address 9] and the line count lies in (address 10, address 11]. Both gates stay low in this mode.
- R10: With control bit 5 at 1, hgate_o follows the horizontal window and vgate_o follows the vertical window independently, and cursor_o stays low.
- R11: vint_o is active on lines in (address 12, address 13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-13 timing, 14 control) |
| wr_data | input | 12 | Register write data |
| hblank_o | output | 1 | Horizontal blank, polarity from control bit 0 |
| hsync_o | output | 1 | Horizontal sync, polarity from control bit 1 |
| vblank_o | output | 1 | Vertical blank, polarity from control bit 2 |
| vsync_o | output | 1 | Vertical sync, polarity from control bit 3 |
| cursor_o | output | 1 | Combined cursor window, active high |
| hgate_o | output | 1 | Horizontal gate in split mode, active high |
| vgate_o | output | 1 | Vertical gate in split mode, active high |
| vint_o | output | 1 | Vertical interrupt strobe, active high |

## Verification
A wrong pixel count shows up on the blank and sync pins within one line, and a wrong line count shows up within one frame. Both appear one clock after the bad state, because every output is registered straight from the counters. A working register copy loaded at the wrong moment distorts the pulse widths for the rest of that frame. A stuck run bit freezes all pins at once. The bench keeps its own arithmetic model of both counters and both register copies, and compares every output on every clock across two contrasting configurations, so a fault of this kind is caught within one frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // timing register slots
  localparam int unsigned IX_HFP  = 0;
  localparam int unsigned IX_HSE  = 1;
  localparam int unsigned IX_HBW  = 2;
  localparam int unsigned IX_HTOT = 3;
  localparam int unsigned IX_VFP  = 4;
  localparam int unsigned IX_VSE  = 5;
  localparam int unsigned IX_VBW  = 6;
  localparam int unsigned IX_VTOT = 7;
  localparam int unsigned IX_HCS  = 8;
  localparam int unsigned IX_HCE  = 9;
  localparam int unsigned IX_VCS  = 10;
  localparam int unsigned IX_VCE  = 11;
  localparam int unsigned IX_VIA  = 12;
  localparam int unsigned IX_VID  = 13;
  localparam int unsigned NTIME   = 14;
  localparam int unsigned IX_CTRL = 14;

  // control word layout
  localparam int unsigned CB_RUN   = 4;
  localparam int unsigned CB_SPLIT = 5;
  localparam int unsigned CTRL_W   = 6;

  // output bit order
  localparam int unsigned OB_HBL = 0;
  localparam int unsigned OB_HSY = 1;
  localparam int unsigned OB_VBL = 2;
  localparam int unsigned OB_VSY = 3;
  localparam int unsigned OB_CUR = 4;
  localparam int unsigned OB_HG  = 5;
  localparam int unsigned OB_VG  = 6;
  localparam int unsigned OB_VI  = 7;
  localparam int unsigned NOUT   = 8;

  // half-open window: true when lo < c <= hi (one-based edge rule)
  function automatic logic in_window(input logic [15:0] c, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (c > lo) && (c <= hi);
  endfunction

  // drive level for a logical pulse under a polarity bit (1 = active high)
  function automatic logic pin_level(input logic active, input logic pol);
    return active ~^ pol;
  endfunction
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  input  logic                        load,
  output logic [NTIME-1:0][DW-1:0]    act_o,
  output logic [CTRL_W-1:0]           ctrl_o
);
  logic [NTIME-1:0][DW-1:0] shadow_q;

  function automatic logic [DW-1:0] even_down(input logic [DW-1:0] v);
    return {v[DW-1:1], 1'b0};
  endfunction

  for (genvar gi = 0; gi < NTIME; gi++) begin : g_slot
    logic hit;
    assign hit = we && (addr == AW'(gi));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[gi] <= '0;
      end else if (hit) begin
        if (gi == IX_HTOT) shadow_q[gi] <= even_down(wdata);
        else               shadow_q[gi] <= wdata;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    act_o[gi] <= '0;
      else if (load) act_o[gi] <= shadow_q[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                ctrl_o <= '0;
    else if (we && addr == AW'(IX_CTRL))       ctrl_o <= wdata[CTRL_W-1:0];
  end
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [DW-1:0] limit,
  output logic [DW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  assign last_o = (cnt_o >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_o <= ONE;
    else if (step) cnt_o <= last_o ? ONE : cnt_o + ONE;
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0]            hcnt,
  input  logic [DW-1:0]            vcnt,
  input  logic [NTIME-1:0][DW-1:0] act,
  input  logic                     split,
  output logic [NOUT-1:0]          act_bits_o
);
  logic hwin, vwin;

  function automatic logic win(input logic [DW-1:0] c, input logic [DW-1:0] lo,
                               input logic [DW-1:0] hi);
    return in_window(16'(c), 16'(lo), 16'(hi));
  endfunction

  assign hwin = win(hcnt, act[IX_HCS], act[IX_HCE]);
  assign vwin = win(vcnt, act[IX_VCS], act[IX_VCE]);

  always_comb begin
    act_bits_o         = '0;
    act_bits_o[OB_HBL] = win(hcnt, '0, act[IX_HBW]);
    act_bits_o[OB_HSY] = win(hcnt, act[IX_HFP], act[IX_HSE]);
    act_bits_o[OB_VBL] = win(vcnt, '0, act[IX_VBW]);
    act_bits_o[OB_VSY] = win(vcnt, act[IX_VFP], act[IX_VSE]);
    act_bits_o[OB_CUR] = !split && hwin && vwin;
    act_bits_o[OB_HG]  = split && hwin;
    act_bits_o[OB_VG]  = split && vwin;
    act_bits_o[OB_VI]  = win(vcnt, act[IX_VIA], act[IX_VID]);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hblank_o,
  output logic          hsync_o,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic          cursor_o,
  output logic          hgate_o,
  output logic          vgate_o,
  output logic          vint_o
);
  logic [NTIME-1:0][DW-1:0] act;
  logic [CTRL_W-1:0]        ctrl;
  logic [DW-1:0]            hcnt, vcnt;
  logic                     run, split;
  logic                     line_end, frame_last, frame_end, load_evt;
  logic [NOUT-1:0]          nxt_bits, out_q;

  // named events for the checker
  assign run       = ctrl[CB_RUN];
  assign split     = ctrl[CB_SPLIT];
  assign frame_end = run && line_end && frame_last;
  assign load_evt  = !run || frame_end;

  rtg_regbank #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(wr_addr), .wdata(wr_data),
    .load(load_evt), .act_o(act), .ctrl_o(ctrl)
  );

  rtg_counter #(.DW(DW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step(run), .limit(act[IX_HTOT]),
    .cnt_o(hcnt), .last_o(line_end)
  );

  rtg_counter #(.DW(DW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(run && line_end), .limit(act[IX_VTOT]),
    .cnt_o(vcnt), .last_o(frame_last)
  );

  rtg_decode #(.DW(DW)) u_dec (
    .hcnt(hcnt), .vcnt(vcnt), .act(act), .split(split), .act_bits_o(nxt_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt_bits;
  end

  assign hblank_o = pin_level(out_q[OB_HBL], ctrl[OB_HBL]);
  assign hsync_o  = pin_level(out_q[OB_HSY], ctrl[OB_HSY]);
  assign vblank_o = pin_level(out_q[OB_VBL], ctrl[OB_VBL]);
  assign vsync_o  = pin_level(out_q[OB_VSY], ctrl[OB_VSY]);
  assign cursor_o = out_q[OB_CUR];
  assign hgate_o  = out_q[OB_HG];
  assign vgate_o  = out_q[OB_VG];
  assign vint_o   = out_q[OB_VI];
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          line_end,
  input logic          frame_end,
  input logic          load_evt,
  input logic [DW-1:0] hcnt,
  input logic [DW-1:0] vcnt,
  input logic [DW-1:0] htot_act,
  input logic          cursor_o,
  input logic          hgate_o,
  input logic          vgate_o
);
  a_r2_hcnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt != '0);
  a_r2_hwrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && line_end |=> hcnt == DW'(1));
  a_r2_hstep: assert property (@(posedge clk) disable iff (!rst_n)
    run && !line_end |=> hcnt == $past(hcnt) + DW'(1));
  a_r5_vstep: assert property (@(posedge clk) disable iff (!rst_n)
    run && line_end && !frame_end |=> vcnt == $past(vcnt) + DW'(1));
  a_r5_vwrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> vcnt == DW'(1));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(hcnt) && $stable(vcnt));
  a_r8_load_window: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(htot_act));
  a_r3_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    htot_act[0] == 1'b0);
  a_r10_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cursor_o && (hgate_o || vgate_o)));
endmodule

bind raster_timing_gen rtg_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
  .frame_end(frame_end), .load_evt(load_evt), .hcnt(hcnt), .vcnt(vcnt),
  .htot_act(act[rtg_pkg::IX_HTOT]), .cursor_o(cursor_o), .hgate_o(hgate_o),
  .vgate_o(vgate_o)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic hblank_o, hsync_o, vblank_o, vsync_o, cursor_o, hgate_o, vgate_o, vint_o;

  int n_chk = 0;
  int n_bad = 0;
  bit live  = 1'b0;

  always #4 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hblank_o(hblank_o), .hsync_o(hsync_o), .vblank_o(vblank_o), .vsync_o(vsync_o),
    .cursor_o(cursor_o), .hgate_o(hgate_o), .vgate_o(vgate_o), .vint_o(vint_o)
  );

  // independent model of the requirements
  logic [11:0] sh [14];
  logic [11:0] ar [14];
  logic [11:0] mh, mv;
  logic [5:0]  mc;
  logic [7:0]  eo;

  function automatic bit between(input logic [11:0] c, input logic [11:0] first_m1,
                                 input logic [11:0] last);
    // active on first_m1+1 .. last
    return (c >= first_m1 + 12'd1) && (c <= last) && (c != 12'd0);
  endfunction

  function automatic logic [7:0] model_bits(input logic [11:0] h, input logic [11:0] v);
    logic [7:0] r;
    bit hw, vw;
    hw = between(h, ar[8], ar[9]);
    vw = between(v, ar[10], ar[11]);
    r[0] = between(h, 12'd0, ar[2]);   // R2
    r[1] = between(h, ar[0], ar[1]);   // R4
    r[2] = between(v, 12'd0, ar[6]);   // R5
    r[3] = between(v, ar[4], ar[5]);   // R5
    r[4] = !mc[5] && hw && vw;         // R9
    r[5] = mc[5] && hw;                // R10
    r[6] = mc[5] && vw;                // R10
    r[7] = between(v, ar[12], ar[13]); // R11
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh <= 12'd1; mv <= 12'd1; mc <= '0; eo <= '0;
      for (int i = 0; i < 14; i++) begin sh[i] <= '0; ar[i] <= '0; end
    end else begin
      if (wr_en) begin
        if (wr_addr == 4'd14) mc <= wr_data[5:0];
        else if (wr_addr < 4'd14)
          sh[wr_addr] <= (wr_addr == 4'd3) ? (wr_data & 12'hFFE) : wr_data; // R3
      end
      eo <= model_bits(mh, mv);
      if (!mc[4] || (mh >= ar[3] && mv >= ar[7]))                          // R8
        for (int i = 0; i < 14; i++) ar[i] <= sh[i];
      if (mc[4]) begin                                                     // R7
        if (mh >= ar[3]) begin
          mh <= 12'd1;
          mv <= (mv >= ar[7]) ? 12'd1 : mv + 12'd1;
        end else mh <= mh + 12'd1;
      end
    end
  end

  function automatic logic [7:0] pins();
    return {vint_o, vgate_o, hgate_o, cursor_o, vsync_o, vblank_o, hsync_o, hblank_o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison of every pin against the model (R6 polarity)
  always @(negedge clk) begin
    if (live) begin
      logic [7:0] exp_p, got;
      got = pins();
      for (int i = 0; i < 8; i++)
        exp_p[i] = (i < 4) ? (eo[i] ? mc[i] : ~mc[i]) : eo[i];
      for (int i = 0; i < 8; i++) begin
        string tag;
        case (i)
          0: tag = "R2/R6/R8 hblank";
          1: tag = "R4/R6 hsync";
          2: tag = "R5/R6 vblank";
          3: tag = "R5/R6 vsync";
          4: tag = "R9 cursor";
          5: tag = "R10 hgate";
          6: tag = "R10 vgate";
          default: tag = "R11 vint";
        endcase
        check(got[i] == exp_p[i], tag, 32'(got[i]), 32'(exp_p[i]));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    int gap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset levels
    check(pins() == 8'h0F, "R1 reset levels", 32'(pins()), 32'h0F);
    live = 1'b1;

    // configuration A: active-low, combined cursor, programmed while stopped
    wr(0, 12'd4); wr(1, 12'd6); wr(2, 12'd3); wr(3, 12'd10);
    wr(4, 12'd1); wr(5, 12'd2); wr(6, 12'd1); wr(7, 12'd5);
    wr(8, 12'd5); wr(9, 12'd8); wr(10, 12'd2); wr(11, 12'd4);
    wr(12, 12'd3); wr(13, 12'd4);
    wr(14, 12'h010);
    repeat (70) @(negedge clk);
    wr(2, 12'd5);                       // R8 mid-frame write, deferred
    repeat (120) @(negedge clk);

    // R7 stop: pins frozen
    wr(14, 12'h000);
    repeat (2) @(negedge clk);
    snap = pins();
    repeat (12) @(negedge clk);
    check(pins() == snap, "R7 hold", 32'(pins()), 32'(snap));

    // configuration B: odd total, active-high, split gates
    wr(0, 12'd2); wr(1, 12'd5); wr(2, 12'd4); wr(3, 12'd13);
    wr(4, 12'd0); wr(5, 12'd1); wr(6, 12'd2); wr(7, 12'd4);
    wr(8, 12'd1); wr(9, 12'd11); wr(10, 12'd1); wr(11, 12'd3);
    wr(12, 12'd0); wr(13, 12'd2);
    wr(14, 12'h03F);
    repeat (3) @(negedge clk);
    // R3: hblank (active high now) rises every 12 clocks
    while (!(hblank_o == 1'b1)) @(negedge clk);
    while (hblank_o == 1'b1) @(negedge clk);
    gap = 0;
    while (hblank_o == 1'b0) begin @(negedge clk); gap++; end
    check(gap == 8, "R3 blank low span", 32'(gap), 32'd8);
    repeat (110) @(negedge clk);

    // R6 polarity flip while running, back to combined cursor
    wr(14, 12'h015);
    repeat (100) @(negedge clk);
    live = 1'b0;
    finish_run();
  end
endmodule